// File: doc/BRIEF.md
# Prescaled 8-bit backlight PWM generator

This block drives a single backlight dimming output. One output period spans 256 steps of an 8-bit counter. The counter advances on ticks of a selected timebase, either every system clock cycle or on a slow tick enable pulse, after a power-of-two divider. An 8-bit compare value sets how many of the 256 steps are active. A polarity bit decides whether the active level is high or low.

Software reaches the block through a simple register port. Writes are single-cycle and reads are combinational. A configuration register holds the compare value, the polarity and the divider code, and a second register holds the timebase select. Two separate write-one strobe addresses start and stop the channel. A status bit follows the start or stop request a fixed two ticks later, so software can poll it to learn whether the channel is really running. New configuration values written while the channel runs are held back until the current period ends.

Top module: `bl_pwm`

## Requirements
- R1: While running, each period lasts 256·2^p ticks of the selected timebase, and the output is active for exactly cmp·2^p of them, where cmp is the compare value and p the divider code.
- R2: Timebase register (address 1) bit 0 set makes every system clock cycle a tick; bit 0 clear makes only cycles with slow_tick_i high count as ticks. It resets to 0.
- R3: The divider code is written at configuration bits [2:0] (address 0). A written code of 7 is stored and read back as 6.
- R4: Configuration bit 4 set makes the active level high; clear makes it low.
- R5: The compare value sits at configuration bits [15:8]. A value of 0 never produces the active level, and 255 gives 255/256 duty, so a fully active period never occurs.
- R6: Writing 1 at bit 0 of address 2 requests start, and writing 1 at bit 0 of address 3 requests stop. A write with bit 0 clear to either address has no effect.
- R7: Status (address 4, bit 0) takes the requested run state exactly two ticks after the strobe. It resets to 0, and the channel runs only while status is 1.
- R8: Configuration changes written while running take effect only at the next wrap of the period counter from 255 to 0.
- R9: While stopped, the output holds the inactive level of the current polarity bit, and the counters are held at zero. The first period after start therefore begins at the active level when cmp is nonzero.
- R10: Reserved configuration bits, and all bits of addresses 2 and 3, read as zero. Bit 0 is the only bit of the timebase register that is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Slow timebase tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Combinational read data |
| pwm_o | output | 1 | PWM output |

## Verification
The duty function is measured by counting active samples over a window of exactly one period. The count is compared against cmp·2^p times the tick spacing, which separates divider, timebase and polarity errors from compare errors. Directed cases cover compare values 0 and 255, divider code 6, a slow tick, and both polarities. Seeded random combinations of compare value, polarity, divider and timebase follow. Two further cases pin down cycle timing: the exact status latency after start and stop, and the lengths of one pulse before and one after a compare value written mid-pulse, which distinguishes deferred from immediate updates.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int CNT_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_MAX  = 6;
  localparam int DW      = 16;
  localparam int AW      = 3;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;

  localparam logic [AW-1:0] A_CFG  = 3'd0;
  localparam logic [AW-1:0] A_TB   = 3'd1;
  localparam logic [AW-1:0] A_ON   = 3'd2;
  localparam logic [AW-1:0] A_OFF  = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          status_i,
  output pwm_cfg_t      cfg_o,
  output logic          tb_sel_o,
  output logic          run_req_o
);
  logic [PS_W-1:0] ps_wr;
  logic            unused_wr;

  assign unused_wr = ^{wr_data_i[CMP_LSB-1:POL_BIT+1], wr_data_i[POL_BIT-1:PS_W]};
  // saturate divider code at the cap
  assign ps_wr = (wr_data_i[PS_W-1:0] > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : wr_data_i[PS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      tb_sel_o  <= 1'b0;
      run_req_o <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CFG: begin
          cfg_o.cmp <= wr_data_i[CMP_LSB +: CNT_W];
          cfg_o.pol <= wr_data_i[POL_BIT];
          cfg_o.ps  <= ps_wr;
        end
        A_TB:  tb_sel_o <= wr_data_i[0];
        A_ON:  if (wr_data_i[0]) run_req_o <= 1'b1;
        A_OFF: if (wr_data_i[0]) run_req_o <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CFG: begin
        rd_data_o[CMP_LSB +: CNT_W] = cfg_o.cmp;
        rd_data_o[POL_BIT]          = cfg_o.pol;
        rd_data_o[PS_W-1:0]         = cfg_o.ps;
      end
      A_TB:   rd_data_o[0] = tb_sel_o;
      A_STAT: rd_data_o[0] = status_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/bl_pwm_sync.sv
module bl_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] st;
  assign st[0] = d_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st[i+1] <= 1'b0;
      else if (tick_i) st[i+1] <= st[i];
    end
  end

  assign q_o = st[STAGES];
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  pwm_cfg_t         cfg_i,
  output pwm_cfg_t         act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  localparam int DIV_W = (PS_MAX > 0) ? PS_MAX : 1;

  logic [DIV_W-1:0] div_q, lim;
  logic             active;

  assign lim    = DIV_W'((1 << act_o.ps) - 1);
  assign adv_o  = run_i & tick_i & (div_q == lim);
  assign wrap_o = adv_o & (cnt_o == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_o <= '0;
      act_o <= '0;
    end else begin
      if (!run_i) begin
        div_q <= '0;
        cnt_o <= '0;
      end else if (tick_i) begin
        if (div_q == lim) begin
          div_q <= '0;
          cnt_o <= cnt_o + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      // shadow follows config when idle, else only at wrap
      if (!run_i || wrap_o) act_o <= cfg_i;
    end
  end

  assign active = run_i & (cnt_o < act_o.cmp);
  assign pwm_o  = active ^ ~act_o.pol;
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          pwm_o
);
  pwm_cfg_t         cfg, act;
  logic             tb_sel, run_req, status, tick, adv, wrap;
  logic [CNT_W-1:0] cnt;

  assign tick = tb_sel | slow_tick_i;

  bl_pwm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .status_i(status), .cfg_o(cfg), .tb_sel_o(tb_sel), .run_req_o(run_req)
  );

  bl_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .tick_i(tick), .d_i(run_req), .q_o(status)
  );

  bl_pwm_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .run_i(status), .cfg_i(cfg),
    .act_o(act), .cnt_o(cnt), .adv_o(adv), .wrap_o(wrap), .pwm_o
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             status,
  input pwm_cfg_t         cfg,
  input pwm_cfg_t         act,
  input logic [CNT_W-1:0] cnt,
  input logic             adv,
  input logic             wrap,
  input logic             pwm_o
);
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && (cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  p_ps_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.ps <= PS_W'(PS_MAX));

  p_zero_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status && (act.cmp == '0) |-> pwm_o == ~act.pol);

  p_stat_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status != $past(status)) |-> $past(tick));

  p_hold_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status && !wrap |=> $stable(act));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status |=> cnt == '0);
endmodule

bind bl_pwm bl_pwm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .status(status), .cfg(cfg),
  .act(act), .cnt(cnt), .adv(adv), .wrap(wrap), .pwm_o(pwm_o)
);

// File: tb/tb_bl_pwm.sv
`timescale 1ns/1ps
module tb_bl_pwm;
  logic        clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = 3'd4;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pwm;
  int checks = 0, errors = 0, sdiv = 4, ph = 0;

  always #2 clk = ~clk;

  bl_pwm dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .pwm_o(pwm)
  );

  initial begin
    forever begin
      @(negedge clk);
      ph = ph + 1;
      if (ph >= sdiv) ph = 0;
      slow_tick = (ph == 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cfgw(input int cmp, input bit pol, input int ps);
    return 16'((cmp << 8) | (int'(pol) << 4) | ps);
  endfunction

  function automatic int exp_active(input int cmp, input int ps, input int spacing);
    return (cmp << ps) * spacing;
  endfunction

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #0.1; v = int'(rd_data); rd_addr = 3'd4;
  endtask

  task automatic wait_stat(input bit v, input string tag);
    int n = 0;
    while (rd_data[0] != v && n < 400) begin @(negedge clk); n++; end
    chk(tag, int'(rd_data[0]), int'(v));
  endtask

  task automatic meas(input int n, input bit lvl, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm == lvl) c++;
    end
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, c, p1, p2;
    bit prev;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset output idle high", int'(pwm), 1);
    chk("R7 reset status", int'(rd_data[0]), 0);
    rd(3'd0, v); chk("R10 reset cfg", v, 0);
    rd(3'd1, v); chk("R2 reset timebase", v, 0);

    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R10 R3 cfg readback cap", v, 16'hFF16);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, v); chk("R10 timebase readback", v, 1);
    wr(3'd2, 16'hFFFE);
    rd(3'd2, v); chk("R10 strobe addr reads zero", v, 0);

    // idle output follows polarity
    wr(3'd0, cfgw(128, 1, 0)); repeat (3) @(negedge clk);
    chk("R9 idle level pol1", int'(pwm), 0);
    wr(3'd0, cfgw(128, 0, 0)); repeat (3) @(negedge clk);
    chk("R9 idle level pol0", int'(pwm), 1);
    repeat (5) @(negedge clk);
    chk("R6 zero enable ignored", int'(rd_data[0]), 0);

    // exact start latency
    wr(3'd0, cfgw(128, 1, 0)); repeat (2) @(negedge clk);
    wr(3'd2, 16'h0001);
    chk("R7 status after 1 tick", int'(rd_data[0]), 0);
    @(negedge clk);
    chk("R7 status after 1 tick b", int'(rd_data[0]), 0);
    @(negedge clk);
    chk("R7 status after 2 ticks", int'(rd_data[0]), 1);
    chk("R9 first step active", int'(pwm), 1);
    meas(256, 1'b1, c); chk("R1 duty 128 p0", c, 128);

    // deferred update
    wr(3'd0, cfgw(200, 1, 0)); repeat (600) @(negedge clk);
    prev = pwm;
    forever begin @(negedge clk); if (pwm && !prev) break; prev = pwm; end
    p1 = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k == 3) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = cfgw(100, 1, 0); end
      if (k == 4) wr_en = 1'b0;
      if (!pwm) break;
      p1++;
    end
    chk("R8 pulse before wrap keeps old compare", p1, 200);
    forever begin @(negedge clk); if (pwm) break; end
    p2 = 1;
    forever begin @(negedge clk); if (!pwm) break; p2++; end
    chk("R8 pulse after wrap uses new compare", p2, 100);

    wr(3'd3, 16'hFFFE); repeat (5) @(negedge clk);
    chk("R6 zero disable ignored", int'(rd_data[0]), 1);
    meas(256, 1'b1, c); chk("R6 still running duty", c, 100);

    wr(3'd0, cfgw(0, 1, 0)); repeat (600) @(negedge clk);
    meas(256, 1'b1, c); chk("R5 compare 0", c, 0);
    wr(3'd0, cfgw(255, 1, 0)); repeat (600) @(negedge clk);
    meas(256, 1'b1, c); chk("R5 compare 255", c, 255);
    wr(3'd0, cfgw(64, 0, 0)); repeat (600) @(negedge clk);
    meas(256, 1'b1, c); chk("R4 active low highs", c, 192);
    wr(3'd0, cfgw(10, 1, 6)); repeat (300) @(negedge clk);
    meas(16384, 1'b1, c); chk("R3 R1 divider 6", c, exp_active(10, 6, 1));

    // exact stop latency
    wr(3'd3, 16'h0001);
    chk("R7 stop status after 0", int'(rd_data[0]), 1);
    @(negedge clk);
    chk("R7 stop status after 1", int'(rd_data[0]), 1);
    @(negedge clk);
    chk("R7 stop status after 2", int'(rd_data[0]), 0);
    chk("R9 stopped inactive", int'(pwm), 0);

    // slow timebase
    sdiv = 4;
    wr(3'd1, 16'h0000);
    wr(3'd0, cfgw(50, 1, 0));
    wr(3'd2, 16'h0001);
    wait_stat(1'b1, "R2 slow start");
    meas(1024, 1'b1, c); chk("R2 slow duty", c, exp_active(50, 0, 4));

    // seeded random mix
    sdiv = 3;
    for (int it = 0; it < 8; it++) begin
      int cmp, ps, sp;
      bit pol, sel;
      cmp = int'($urandom_range(255, 0));
      ps  = int'($urandom_range(2, 0));
      pol = 1'($urandom_range(1, 0));
      sel = 1'($urandom_range(1, 0));
      sp  = sel ? 1 : 3;
      wr(3'd3, 16'h0001);
      wait_stat(1'b0, "R7 random stop");
      wr(3'd1, 16'(sel));
      wr(3'd0, cfgw(cmp, pol, ps));
      wr(3'd2, 16'h0001);
      wait_stat(1'b1, "R7 random start");
      meas((256 << ps) * sp, pol, c);
      chk("R1 R2 R4 random duty", c, exp_active(cmp, ps, sp));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule